// File: doc/BRIEF.md
# Branch Speculation Throttle Controller

This controller lowers frontend power by capping how far the fetch unit may run ahead of branch resolution. It keeps a running count of branches that have been fetched but not yet resolved and raises a fetch stall once that count reaches a limit chosen by the active throttle level. The stall decision uses only this plain count; no branch confidence estimate is involved.

Besides the stall, each throttle level sets the resource limits the rest of the frontend applies: how many fetch-buffer entries are enabled, how many physical registers are enabled, and whether renamer checkpoints are kept. The unthrottled level keeps everything at full size. Every throttled level drops checkpoints entirely (misprediction recovery then happens at commit), trims the fetch buffer to the issue width and halves the register file. A level change that would shrink a structure below what it currently holds is parked as pending and is applied on the first clock edge at which both occupancies fit under the new limits.

The count follows fetched and resolved branch pulses, and a pipeline flush reloads it with the number of older branches that survive the flush.

Top module: `spec_throttle`

## Requirements
- R1: Without a flush, the unresolved-branch count rises by one on a cycle with `br_fetch` only, falls by one on a cycle with `br_resolve` only, and holds when both or neither are high.
- R2: The count saturates: a resolve-only cycle at a count of 0 leaves 0, and a fetch-only cycle at the all-ones count (2^CNT_W-1) leaves that value.
- R3: A cycle with `flush` high loads the count with `flush_keep`, regardless of `br_fetch` and `br_resolve` in that cycle.
- R4: With level code 1, 2, 3, 4 or 5 active, `fetch_stall` is high exactly when the count is at least 8, 4, 3, 2 or 1 respectively.
- R5: With level code 0 (unthrottled) active, `fetch_stall` stays low at any count.
- R6: Level code 0 gives `ckpt_count` 16, `ckpt_en` 1, `fb_depth` 16 and `prf_count` 128; codes 1 to 5 give `ckpt_count` 0, `ckpt_en` 0, `fb_depth` 4 and `prf_count` 64.
- R7: A level write (`lvl_wr` high) carrying code 6 or 7 is ignored: the active level, the pending target and `lvl_pending` are as if no write had occurred.
- R8: A change from level 0 to a throttled level is applied at a clock edge only if at that edge `fb_occ` is below 4 and `prf_occ` is below 64; until then `lvl_pending` is high and the old level stays active.
- R9: A valid level change that shrinks nothing (throttled to throttled, or to level 0) takes effect at the clock edge where it is written, and a later valid write replaces a pending target.
- R10: After reset the count is 0, the active level is 0, `lvl_pending` is low and `fetch_stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_fetch | input | 1 | A branch was fetched this cycle |
| br_resolve | input | 1 | A branch resolved this cycle |
| flush | input | 1 | Pipeline flush; reload the count |
| flush_keep | input | CNT_W | Older branches surviving the flush |
| lvl_wr | input | 1 | Write a new throttle level |
| lvl_data | input | 3 | Requested level code (0 to 5 valid) |
| fb_occ | input | FB_W | Current fetch-buffer occupancy |
| prf_occ | input | PRF_W | Current physical registers in use |
| fetch_stall | output | 1 | Stop fetching |
| br_count | output | CNT_W | Unresolved branches in flight |
| lvl_cur | output | 3 | Active level code |
| lvl_pending | output | 1 | A requested level is waiting for occupancy to drop |
| fb_depth | output | FB_W | Enabled fetch-buffer entries |
| prf_count | output | PRF_W | Enabled physical registers |
| ckpt_count | output | CK_W | Enabled renamer checkpoints |
| ckpt_en | output | 1 | Checkpoint recovery enabled |

## Verification
The bench builds the controller with a 4-bit counter instead of the default 5 bits, so the saturation ceiling of 15 is reached by short bursts of fetches and the random mix of fetch, resolve and flush regularly touches both count limits. All other parameters stay at their defaults, so the threshold ladder 8/4/3/2/1 and the full 16/128 to 4/64 shrink are exercised as specified. Occupancies are drawn across their whole range, which makes the pending case of a shrink both common and regularly released, and invalid level codes appear among the random writes.

// File: rtl/st_pkg.sv
// Shared level encoding for the speculation throttle.
// Assumes level codes 0..LVL_MAX are valid and code 0 is unthrottled.
package st_pkg;
    localparam int LVL_W    = 3;
    localparam int LVL_MAX  = 5;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t LVL_BASE = '0;
endpackage

// File: rtl/st_br_counter.sv
// Unresolved-branch counter.
// Counts fetched minus resolved branches with saturation at both ends.
// Assumes at most one fetch and one resolve per cycle; flush has priority.
module st_br_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Track in-flight branches: flush reload, else +1/-1 with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (inc && !dec && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec && !inc && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count = cnt_q;

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && inc == dec) |=> $stable(count));
    // R3
    flush_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));
    // R2
    zero_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dec && !inc && count == '0) |=> count == '0);
endmodule

// File: rtl/st_limits.sv
// Resource limit decode for one level code.
// Gives the enabled fetch-buffer depth and physical register count.
// Assumes the level code is already valid.
module st_limits #(
    parameter int BASE_FB  = 16,
    parameter int THR_FB   = 4,
    parameter int BASE_PRF = 128,
    parameter int THR_PRF  = 64,
    parameter int FB_W     = $clog2(BASE_FB + 1),
    parameter int PRF_W    = $clog2(BASE_PRF + 1)
) (
    input  st_pkg::lvl_t     lvl,
    output logic [FB_W-1:0]  fb,
    output logic [PRF_W-1:0] prf
);
    // Full size at the unthrottled level, reduced size elsewhere.
    always_comb begin
        if (lvl == st_pkg::LVL_BASE) begin
            fb  = FB_W'(BASE_FB);
            prf = PRF_W'(BASE_PRF);
        end else begin
            fb  = FB_W'(THR_FB);
            prf = PRF_W'(THR_PRF);
        end
    end
endmodule

// File: rtl/st_level_ctrl.sv
// Throttle level register with shrink gating.
// Holds the requested target and the active level. A target that shrinks
// the fetch buffer or register file becomes active only once both
// occupancies are below the new limits. Invalid codes are dropped.
module st_level_ctrl #(
    parameter int BASE_FB  = 16,
    parameter int THR_FB   = 4,
    parameter int BASE_PRF = 128,
    parameter int THR_PRF  = 64,
    parameter int FB_W     = $clog2(BASE_FB + 1),
    parameter int PRF_W    = $clog2(BASE_PRF + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  st_pkg::lvl_t     wr_lvl,
    input  logic [FB_W-1:0]  fb_occ,
    input  logic [PRF_W-1:0] prf_occ,
    output st_pkg::lvl_t     cur,
    output logic             pending,
    output logic [FB_W-1:0]  cur_fb,
    output logic [PRF_W-1:0] cur_prf
);
    st_pkg::lvl_t     tgt_q, cur_q, eff;
    logic [FB_W-1:0]  eff_fb;
    logic [PRF_W-1:0] eff_prf;
    logic             fits;

    // Pick the target for this edge: a valid write, else the held one.
    always_comb begin
        if (wr && wr_lvl <= st_pkg::lvl_t'(st_pkg::LVL_MAX)) eff = wr_lvl;
        else                                                 eff = tgt_q;
    end

    st_limits #(.BASE_FB(BASE_FB), .THR_FB(THR_FB), .BASE_PRF(BASE_PRF),
                .THR_PRF(THR_PRF), .FB_W(FB_W), .PRF_W(PRF_W))
        u_lim_cur (.lvl(cur_q), .fb(cur_fb), .prf(cur_prf));

    st_limits #(.BASE_FB(BASE_FB), .THR_FB(THR_FB), .BASE_PRF(BASE_PRF),
                .THR_PRF(THR_PRF), .FB_W(FB_W), .PRF_W(PRF_W))
        u_lim_eff (.lvl(eff), .fb(eff_fb), .prf(eff_prf));

    // A structure that grows or keeps size always fits; a shrink needs room.
    always_comb begin
        fits = (eff_fb  >= cur_fb  || fb_occ  < eff_fb) &&
               (eff_prf >= cur_prf || prf_occ < eff_prf);
    end

    // Latch the target and move the active level when it fits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= st_pkg::LVL_BASE;
            cur_q <= st_pkg::LVL_BASE;
        end else begin
            tgt_q <= eff;
            if (fits) cur_q <= eff;
        end
    end

    assign cur     = cur_q;
    assign pending = (tgt_q != cur_q);

    // R7
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_lvl > st_pkg::lvl_t'(st_pkg::LVL_MAX) && !pending)
        |=> (cur == $past(cur)) && !pending);
    // R8
    shrink_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_fb < $past(cur_fb)) |-> ($past(fb_occ) < cur_fb && $past(prf_occ) < cur_prf));
    // R8
    valid_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur <= st_pkg::lvl_t'(st_pkg::LVL_MAX));
endmodule

// File: rtl/st_throttle_gate.sv
// Stall and checkpoint decode for the active level.
// Stalls fetch when the unresolved count reaches the level threshold;
// the unthrottled level never stalls and is the only one with checkpoints.
module st_throttle_gate #(
    parameter int CNT_W     = 5,
    parameter int BASE_CKPT = 16,
    parameter int THR1      = 8,
    parameter int THR2      = 4,
    parameter int THR3      = 3,
    parameter int THR4      = 2,
    parameter int THR5      = 1,
    parameter int CK_W      = $clog2(BASE_CKPT + 1)
) (
    input  st_pkg::lvl_t     lvl,
    input  logic [CNT_W-1:0] count,
    output logic             stall,
    output logic [CK_W-1:0]  ckpt_count,
    output logic             ckpt_en
);
    localparam int NTHR = 5;
    localparam int THR_TAB [NTHR] = '{THR1, THR2, THR3, THR4, THR5};

    logic [NTHR-1:0] hit;

    // One comparator per throttled level, selected by the level code.
    for (genvar g = 0; g < NTHR; g++) begin : g_thr
        assign hit[g] = (lvl == st_pkg::lvl_t'(g + 1)) &&
                        ({1'b0, count} >= (CNT_W+1)'(THR_TAB[g]));
    end

    // Drive stall and checkpoint settings from the level.
    always_comb begin
        stall      = |hit;
        ckpt_en    = (lvl == st_pkg::LVL_BASE);
        ckpt_count = ckpt_en ? CK_W'(BASE_CKPT) : '0;
    end
endmodule

// File: rtl/spec_throttle.sv
// Branch speculation throttle controller (top).
// Counts unresolved branches, stalls fetch at the active level's limit and
// publishes the level's fetch-buffer, register and checkpoint settings.
// Assumes one fetch and one resolve pulse per cycle at most.
module spec_throttle #(
    parameter int CNT_W     = 5,
    parameter int BASE_FB   = 16,
    parameter int THR_FB    = 4,
    parameter int BASE_PRF  = 128,
    parameter int THR_PRF   = 64,
    parameter int BASE_CKPT = 16,
    parameter int THR1      = 8,
    parameter int THR2      = 4,
    parameter int THR3      = 3,
    parameter int THR4      = 2,
    parameter int THR5      = 1,
    parameter int FB_W      = $clog2(BASE_FB + 1),
    parameter int PRF_W     = $clog2(BASE_PRF + 1),
    parameter int CK_W      = $clog2(BASE_CKPT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_fetch,
    input  logic             br_resolve,
    input  logic             flush,
    input  logic [CNT_W-1:0] flush_keep,
    input  logic             lvl_wr,
    input  logic [2:0]       lvl_data,
    input  logic [FB_W-1:0]  fb_occ,
    input  logic [PRF_W-1:0] prf_occ,
    output logic             fetch_stall,
    output logic [CNT_W-1:0] br_count,
    output logic [2:0]       lvl_cur,
    output logic             lvl_pending,
    output logic [FB_W-1:0]  fb_depth,
    output logic [PRF_W-1:0] prf_count,
    output logic [CK_W-1:0]  ckpt_count,
    output logic             ckpt_en
);
    st_br_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(br_fetch), .dec(br_resolve),
        .load(flush), .load_val(flush_keep), .count(br_count));

    st_level_ctrl #(.BASE_FB(BASE_FB), .THR_FB(THR_FB), .BASE_PRF(BASE_PRF),
                    .THR_PRF(THR_PRF), .FB_W(FB_W), .PRF_W(PRF_W)) u_lvl (
        .clk(clk), .rst_n(rst_n), .wr(lvl_wr), .wr_lvl(lvl_data),
        .fb_occ(fb_occ), .prf_occ(prf_occ), .cur(lvl_cur),
        .pending(lvl_pending), .cur_fb(fb_depth), .cur_prf(prf_count));

    st_throttle_gate #(.CNT_W(CNT_W), .BASE_CKPT(BASE_CKPT), .THR1(THR1),
                       .THR2(THR2), .THR3(THR3), .THR4(THR4), .THR5(THR5),
                       .CK_W(CK_W)) u_gate (
        .lvl(lvl_cur), .count(br_count), .stall(fetch_stall),
        .ckpt_count(ckpt_count), .ckpt_en(ckpt_en));

    // R5
    base_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_cur == 3'd0) |-> !fetch_stall);
    // R6
    ckpt_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_en |-> (fb_depth == FB_W'(BASE_FB) && prf_count == PRF_W'(BASE_PRF)));
    // R4
    deepest_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_cur == 3'd5 && br_count != '0) |-> fetch_stall);
endmodule

// File: tb/test_spec_throttle.sv
// Self-checking bench: directed corners plus seeded random traffic,
// compared with a bench-side model of the requirements.
module test_spec_throttle;
    localparam int CNT_W = 4;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n;
    logic br_fetch, br_resolve, flush, lvl_wr;
    logic [CNT_W-1:0] flush_keep;
    logic [2:0] lvl_data;
    logic [4:0] fb_occ;
    logic [7:0] prf_occ;
    logic fetch_stall, lvl_pending, ckpt_en;
    logic [CNT_W-1:0] br_count;
    logic [2:0] lvl_cur;
    logic [4:0] fb_depth, ckpt_count;
    logic [7:0] prf_count;

    spec_throttle #(.CNT_W(CNT_W)) i_spec_throttle (
        .clk(clk), .rst_n(rst_n), .br_fetch(br_fetch), .br_resolve(br_resolve),
        .flush(flush), .flush_keep(flush_keep), .lvl_wr(lvl_wr),
        .lvl_data(lvl_data), .fb_occ(fb_occ), .prf_occ(prf_occ),
        .fetch_stall(fetch_stall), .br_count(br_count), .lvl_cur(lvl_cur),
        .lvl_pending(lvl_pending), .fb_depth(fb_depth), .prf_count(prf_count),
        .ckpt_count(ckpt_count), .ckpt_en(ckpt_en));

    always #10 clk = ~clk;

    int tests = 0, fails = 0;
    int mc, ml, mt;
    string cnt_tag, lvl_tag;

    function automatic int m_thr(int l);
        case (l) 1: return 8; 2: return 4; 3: return 3; 4: return 2; 5: return 1;
            default: return 1000;
        endcase
    endfunction
    function automatic int m_fb(int l);  return (l == 0) ? 16 : 4;  endfunction
    function automatic int m_prf(int l); return (l == 0) ? 128 : 64; endfunction

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk(cnt_tag, int'(br_count), mc);
        chk((ml == 0) ? "R5 stall" : "R4 stall", int'(fetch_stall), (mc >= m_thr(ml)) ? 1 : 0);
        chk(lvl_tag, int'(lvl_cur), ml);
        chk({lvl_tag, " pending"}, int'(lvl_pending), (mt != ml) ? 1 : 0);
        chk("R6 fb", int'(fb_depth), m_fb(ml));
        chk("R6 prf", int'(prf_count), m_prf(ml));
        chk("R6 ckpt", int'(ckpt_count), (ml == 0) ? 16 : 0);
        chk("R6 ckpt_en", int'(ckpt_en), (ml == 0) ? 1 : 0);
    endtask

    // Drive one cycle at the falling edge, advance the model, check after.
    task automatic cyc(bit f, bit r, bit fl, int k, bit wr, int d, int fo, int po);
        int eff;
        bit fits;
        br_fetch = f; br_resolve = r; flush = fl; flush_keep = CNT_W'(k);
        lvl_wr = wr; lvl_data = 3'(d); fb_occ = 5'(fo); prf_occ = 8'(po);
        if (fl) begin mc = k; cnt_tag = "R3 count"; end
        else if (f && !r) begin
            cnt_tag = (mc == MAXC) ? "R2 count" : "R1 count";
            if (mc != MAXC) mc++;
        end else if (r && !f) begin
            cnt_tag = (mc == 0) ? "R2 count" : "R1 count";
            if (mc != 0) mc--;
        end else cnt_tag = "R1 count";
        eff = (wr && d <= 5) ? d : mt;
        if (wr && d <= 5) mt = d;
        fits = (m_fb(eff) >= m_fb(ml) || fo < m_fb(eff)) &&
               (m_prf(eff) >= m_prf(ml) || po < m_prf(eff));
        if (wr && d > 5) lvl_tag = "R7 level";
        else if (m_fb(eff) < m_fb(ml)) lvl_tag = "R8 level";
        else lvl_tag = "R9 level";
        if (fits) ml = eff;
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        int c;
        c = 0;
        while (c < 100000) begin @(posedge clk); c++; end
        fails++;
        $display("FAIL watchdog: got %0d expected %0d", c, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        br_fetch = 0; br_resolve = 0; flush = 0; flush_keep = '0;
        lvl_wr = 0; lvl_data = '0; fb_occ = '0; prf_occ = '0;
        mc = 0; ml = 0; mt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 count", int'(br_count), 0);
        chk("R10 level", int'(lvl_cur), 0);
        chk("R10 pending", int'(lvl_pending), 0);
        chk("R10 stall", int'(fetch_stall), 0);
        // R2 climb to the ceiling at base level, R5 no stall
        for (int i = 0; i < MAXC + 3; i++) cyc(1, 0, 0, 0, 0, 0, 20, 200);
        for (int i = 0; i < MAXC + 3; i++) cyc(0, 1, 0, 0, 0, 0, 20, 200);
        // R8 shrink blocked by occupancy, then released
        cyc(0, 0, 0, 0, 1, 1, 10, 10);
        cyc(0, 0, 0, 0, 0, 0, 3, 100);
        cyc(0, 0, 0, 0, 0, 0, 3, 63);
        // R4 walk up to threshold 8; R7 invalid code while active
        for (int i = 0; i < 9; i++) cyc(1, 0, 0, 0, 0, 0, 16, 128);
        cyc(0, 0, 0, 0, 1, 7, 0, 0);
        // R9 throttled to throttled immediately, then back to base
        for (int l = 2; l <= 5; l++) cyc(0, 0, 0, 0, 1, l, 16, 128);
        cyc(0, 0, 1, 1, 0, 0, 16, 128);
        cyc(0, 1, 0, 0, 1, 0, 16, 128);
        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            cyc(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                ($urandom_range(0, 15) == 0), int'($urandom_range(0, MAXC)),
                ($urandom_range(0, 7) == 0), int'($urandom_range(0, 7)),
                int'($urandom_range(0, 16)), int'($urandom_range(0, 128)));
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule